// File: doc/BRIEF.md
# Byte-lane Rotating Width-converting FIFO

This block is a single-clock character buffer whose two sides may each move one or two 8-bit characters per clock. A producer that can deliver a pair of characters at once is never held back by a consumer that takes them one at a time, and the reverse also holds. Storage is two independent byte-wide lanes. Each lane is a first-word-fall-through queue, so its oldest character is always visible without a read latency.

Consecutive characters alternate between the two lanes. A write-lane pointer names the lane that takes the next incoming character, and a read-lane pointer names the lane that holds the next outgoing one. A two-character transfer touches both lanes and leaves its pointer unchanged. A one-character transfer touches only the named lane and flips the pointer. Because of this, a transfer of odd length never leaves a gap, and no padding is ever stored.

Each pointer is a two-state machine with the states `LANE0` and `LANE1`. The machine has two transitions. In `LANE0`, an accepted single-character transfer moves it to `LANE1`. In `LANE1`, an accepted single-character transfer moves it back to `LANE0`. Every other cycle holds the current state. Reset puts both machines in `LANE0`.

Top module: `duallane_char_fifo`

## Requirements
- R1: Characters leave in exactly the order in which they were accepted, across any mix of one- and two-character writes and reads, and no accepted character is lost.
- R2: An accepted write with `wr_single`=0 stores two characters in one clock. `wr_data[7:0]` is the earlier character and `wr_data[15:8]` is the later one.
- R3: An accepted write with `wr_single`=1 stores only `wr_data[7:0]` and ignores `wr_data[15:8]`. The next character then goes to the other lane, so two single writes of 0x11 and then 0x22 read back as the pair 0x2211.
- R4: `wr_full` depends on the request. With `wr_single`=1 it is high when the current write lane holds LANE_DEPTH characters. With `wr_single`=0 it is high when either lane is full. A write presented while `wr_full` is high stores nothing.
- R5: `rd_empty` depends on the request. With `rd_single`=1 it is high when the current read lane holds no character. With `rd_single`=0 it is high when either lane holds none, so fewer than two characters are stored. A read presented while `rd_empty` is high removes nothing.
- R6: `rd_data[7:0]` shows the oldest stored character. With `rd_single`=0, `rd_data[15:8]` shows the second-oldest character. With `rd_single`=1, `rd_data[15:8]` reads 0x00.
- R7: An accepted read with `rd_single`=1 removes exactly one character, and the next oldest character then appears on `rd_data[7:0]`. A consumer that takes one character per read therefore receives the stream one character at a time.
- R8: `count` equals the total number of stored characters. It takes its new value right after the clock edge that performs a transfer. When a write and a read are both accepted in the same cycle, `count` changes by the difference between characters written and characters read.
- R9: A synchronous active-high `rst` empties both lanes and returns both pointers to lane 0. After reset, `count`=0, `rd_empty`=1 and `wr_full`=0.
- R10: The buffer holds 2*LANE_DEPTH characters. After 2*LANE_DEPTH-1 single writes, a pair write is refused while a single write is still accepted. Once the buffer is full, both kinds of write are refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_single | input | 1 | 1: write one character, 0: write two |
| wr_data | input | 16 | Characters to write, earlier one in [7:0] |
| wr_full | output | 1 | The requested write cannot be accepted |
| rd_en | input | 1 | Read request |
| rd_single | input | 1 | 1: read one character, 0: read two |
| rd_data | output | 16 | Oldest character in [7:0], next one in [15:8] |
| rd_empty | output | 1 | The requested read cannot be served |
| count | output | $clog2(2*LANE_DEPTH+1) | Number of stored characters |

## Verification
The bench first runs directed sequences. Two single writes read back as one pair, which separates correct lane rotation from a design that pads or overwrites. Single reads drain a pair, which shows that the read pointer advances. An odd-count fill stops exactly where the pair write and the single write disagree on fullness. The bench then sweeps all sixteen combinations of write, write-width, read and read-width cyclically, and adds write-heavy, balanced and read-heavy pseudo-random phases. These phases push the lanes through full, empty and every fill level in between, with both pointer parities. Each cycle, a character-index model predicts the per-request full and empty flags, both output bytes and the count.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
    typedef enum logic {
        LANE0 = 1'b0,
        LANE1 = 1'b1
    } lane_e;
endpackage

// File: rtl/char_lane.sv
module char_lane #(
    parameter int DEPTH = 8,
    parameter int CW    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  logic [CW-1:0]             din,
    input  logic                      pop,
    output logic [CW-1:0]             head,
    output logic                      is_empty,
    output logic                      is_full,
    output logic [$clog2(DEPTH):0]    occ
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = AW + 1;

    logic [CW-1:0] mem [DEPTH];
    logic [AW-1:0] head_ptr;
    logic [AW-1:0] tail_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            occ      <= '0;
        end else begin
            if (push) tail_ptr <= tail_ptr + AW'(1);
            if (pop)  head_ptr <= head_ptr + AW'(1);
            unique case ({push, pop})
                2'b10:   occ <= occ + CNTW'(1);
                2'b01:   occ <= occ - CNTW'(1);
                default: occ <= occ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[tail_ptr] <= din;
    end

    assign head     = mem[head_ptr];
    assign is_empty = (occ == '0);
    assign is_full  = (occ == CNTW'(DEPTH));

    // R4: the lane is never pushed while it is full
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        push |-> !is_full);

    // R5: the lane is never popped while it is empty
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> !is_empty);
endmodule

// File: rtl/lane_rotor.sv
module lane_rotor
    import dlf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_step,
    input  logic  rd_step,
    output lane_e wr_lane,
    output lane_e rd_lane
);
    lane_e wr_nxt;
    lane_e rd_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_lane <= LANE0;
            rd_lane <= LANE0;
        end else begin
            wr_lane <= wr_nxt;
            rd_lane <= rd_nxt;
        end
    end

    always_comb begin
        wr_nxt = wr_lane;
        unique case (wr_lane)
            LANE0: if (wr_step) wr_nxt = LANE1;
            LANE1: if (wr_step) wr_nxt = LANE0;
        endcase
        rd_nxt = rd_lane;
        unique case (rd_lane)
            LANE0: if (rd_step) rd_nxt = LANE1;
            LANE1: if (rd_step) rd_nxt = LANE0;
        endcase
    end
endmodule

// File: rtl/duallane_char_fifo.sv
module duallane_char_fifo
    import dlf_pkg::*;
#(
    parameter int LANE_DEPTH = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic                                wr_single,
    input  logic [15:0]                         wr_data,
    output logic                                wr_full,
    input  logic                                rd_en,
    input  logic                                rd_single,
    output logic [15:0]                         rd_data,
    output logic                                rd_empty,
    output logic [$clog2(2*LANE_DEPTH+1)-1:0]   count
);
    localparam int NLANES = 2;
    localparam int LCW    = $clog2(LANE_DEPTH) + 1;
    localparam int CNTW   = $clog2(2*LANE_DEPTH+1);

    lane_e wr_lane;
    lane_e rd_lane;
    logic  wl;
    logic  rl;
    logic  wr_go;
    logic  rd_go;

    logic [NLANES-1:0] lane_push;
    logic [NLANES-1:0] lane_pop;
    logic [NLANES-1:0] lane_empty;
    logic [NLANES-1:0] lane_full;
    logic [7:0]        lane_din  [NLANES];
    logic [7:0]        lane_head [NLANES];
    logic [LCW-1:0]    lane_occ  [NLANES];

    assign wl = wr_lane;
    assign rl = rd_lane;

    assign wr_full  = wr_single ? lane_full[wl]  : (lane_full[0]  | lane_full[1]);
    assign rd_empty = rd_single ? lane_empty[rl] : (lane_empty[0] | lane_empty[1]);
    assign wr_go    = wr_en & ~wr_full;
    assign rd_go    = rd_en & ~rd_empty;

    lane_rotor u_rotor (
        .clk     (clk),
        .rst     (rst),
        .wr_step (wr_go & wr_single),
        .rd_step (rd_go & rd_single),
        .wr_lane (wr_lane),
        .rd_lane (rd_lane)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic wr_first;
        logic rd_first;
        assign wr_first     = (wl == 1'(g));
        assign rd_first     = (rl == 1'(g));
        assign lane_din[g]  = wr_first ? wr_data[7:0] : wr_data[15:8];
        assign lane_push[g] = wr_go & (wr_first | ~wr_single);
        assign lane_pop[g]  = rd_go & (rd_first | ~rd_single);

        char_lane #(.DEPTH(LANE_DEPTH), .CW(8)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .push     (lane_push[g]),
            .din      (lane_din[g]),
            .pop      (lane_pop[g]),
            .head     (lane_head[g]),
            .is_empty (lane_empty[g]),
            .is_full  (lane_full[g]),
            .occ      (lane_occ[g])
        );
    end

    assign rd_data = {(rd_single ? 8'h00 : lane_head[~rl]), lane_head[rl]};
    assign count   = CNTW'(lane_occ[0]) + CNTW'(lane_occ[1]);

    // R1: lane occupancies stay interleaved: their difference matches the pointer offset
    assert_lane_balance_R1: assert property (@(posedge clk) disable iff (rst)
        (int'(lane_occ[0]) - int'(lane_occ[1])) == (int'(wl) - int'(rl)));

    // R8: a lone accepted single write raises the count by one
    assert_count_single_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_go && wr_single && !rd_go) |=> count == $past(count) + CNTW'(1));

    // R8: a lone accepted pair read lowers the count by two
    assert_count_pair_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_go && !rd_single && !wr_go) |=> count == $past(count) - CNTW'(2));

    // R9: reset leaves both lanes empty
    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (count == '0) && (lane_empty == 2'b11));
endmodule

// File: tb/duallane_char_fifo_test.sv
module duallane_char_fifo_test;
    localparam int CLK_PERIOD = 10;
    localparam int D          = 4;
    localparam int CNTW       = $clog2(2*D+1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic            wr_single = 1'b0;
    logic [15:0]     wr_data = '0;
    logic            wr_full;
    logic            rd_en = 1'b0;
    logic            rd_single = 1'b0;
    logic [15:0]     rd_data;
    logic            rd_empty;
    logic [CNTW-1:0] count;

    int checks = 0;
    int errors = 0;
    int wr_total = 0;
    int rd_total = 0;
    logic [7:0] model [256];
    logic [15:0] lfsr = 16'hACE1;

    duallane_char_fifo #(.LANE_DEPTH(D)) uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_single(wr_single), .wr_data(wr_data), .wr_full(wr_full),
        .rd_en(rd_en), .rd_single(rd_single), .rd_data(rd_data), .rd_empty(rd_empty),
        .count(count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lane_cnt(int lane);
        int c = 0;
        for (int k = rd_total; k < wr_total; k++) if (k % 2 == lane) c++;
        return c;
    endfunction

    task automatic step(bit we, bit ws, logic [15:0] wd, bit re, bit rs);
        int l0, l1, lw, lr;
        bit exp_full, exp_empty;
        @(negedge clk);
        wr_en = we; wr_single = ws; wr_data = wd; rd_en = re; rd_single = rs;
        #1;
        l0 = lane_cnt(0);
        l1 = lane_cnt(1);
        lw = (wr_total % 2 == 0) ? l0 : l1;
        lr = (rd_total % 2 == 0) ? l0 : l1;
        exp_full  = ws ? (lw == D) : (l0 == D || l1 == D);
        exp_empty = rs ? (lr == 0) : (l0 == 0 || l1 == 0);
        chk("R4 wr_full", int'(wr_full), int'(exp_full));
        chk("R5 rd_empty", int'(rd_empty), int'(exp_empty));
        chk("R8 count", int'(count), wr_total - rd_total);
        if (!exp_empty) begin
            chk("R1 rd_data low char", int'(rd_data[7:0]), int'(model[rd_total % 256]));
            if (rs) chk("R6 upper byte zero", int'(rd_data[15:8]), 0);
            else    chk("R2 rd_data high char", int'(rd_data[15:8]), int'(model[(rd_total+1) % 256]));
        end
        if (we && !exp_full) begin
            model[wr_total % 256] = wd[7:0];
            wr_total++;
            if (!ws) begin
                model[wr_total % 256] = wd[15:8];
                wr_total++;
            end
        end
        if (re && !exp_empty) rd_total += rs ? 1 : 2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 0; rd_en = 0; wr_single = 0; rd_single = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wr_total = 0;
        rd_total = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk("R9 count after reset", int'(count), 0);
        chk("R9 rd_empty after reset", int'(rd_empty), 1);
        chk("R9 wr_full after reset", int'(wr_full), 0);
        rd_single = 1'b1; #1;
        chk("R9 single rd_empty after reset", int'(rd_empty), 1);

        // R3: two single writes, upper bytes ignored, read as one pair
        step(1, 1, 16'hEE11, 0, 0);
        step(1, 1, 16'hDD22, 0, 0);
        step(0, 0, 16'h0000, 0, 0);
        chk("R3 pair from singles", int'(rd_data), 16'h2211);

        // R7: byte-at-a-time consumer
        step(0, 0, 16'h0000, 1, 1);
        step(0, 0, 16'h0000, 0, 1);
        chk("R7 next char after single read", int'(rd_data[7:0]), 8'h22);
        step(0, 0, 16'h0000, 1, 1);
        step(0, 0, 16'h0000, 0, 0);
        chk("R7 drained", int'(count), 0);

        // R10: odd fill boundary, then full
        for (int i = 1; i <= 2*D-1; i++) step(1, 1, 16'(i), 0, 0);
        step(0, 0, 16'h0000, 0, 0);
        chk("R10 pair refused at 2D-1", int'(wr_full), 1);
        step(0, 1, 16'h0000, 0, 0);
        chk("R10 single accepted at 2D-1", int'(wr_full), 0);
        step(1, 1, 16'h0008, 0, 0);
        step(1, 0, 16'hBEEF, 0, 0);
        step(0, 1, 16'h0000, 0, 0);
        chk("R10 single refused when full", int'(wr_full), 1);
        chk("R10 capacity", int'(count), 2*D);
        for (int i = 0; i < D; i++) step(0, 0, 16'h0000, 1, 0);
        step(0, 0, 16'h0000, 0, 0);
        chk("R10 refused write left nothing", int'(count), 0);

        // near-exhaustive cyclic sweep of control combinations
        for (int rep = 0; rep < 64; rep++) begin
            for (int c = 0; c < 16; c++) begin
                step(c[0], c[1], 16'((rep * 16 + c) * 16'h0123 + 16'h4567), c[2], c[3]);
            end
        end

        // biased pseudo-random phases: write-heavy, balanced, read-heavy
        for (int ph = 0; ph < 3; ph++) begin
            for (int i = 0; i < 800; i++) begin
                bit we, re;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                we = (ph == 0) ? 1'b1 : (ph == 1) ? lfsr[0] : (lfsr[0] & lfsr[1]);
                re = (ph == 2) ? 1'b1 : (ph == 1) ? lfsr[2] : (lfsr[2] & lfsr[3]);
                step(we, lfsr[4], lfsr ^ 16'h5A3C, re, lfsr[5]);
            end
        end

        step(0, 0, 16'h0000, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule